// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block compares two slow digital clocks, a reference and a divided feedback, in a fast system clock domain. Both inputs pass through two-stage synchronisers, and their rising edges set one of two correction flags. An edge on the reference sets the "up" flag. An edge on the feedback sets the "down" flag. When both flags are set, a short clearing delay resets them together. The time one flag is held alone therefore equals the phase lead of its input.

A combined error output is high while exactly one flag is set, so its width follows the phase error and it can drive an external integrator. A frequency difference leaves one flag set across whole periods, so the detector also steers toward frequency agreement. An active-high lock output goes low whenever either flag is set. On an aligned loop it therefore shows only the brief overlap pulse, and on a misaligned loop it shows much wider low pulses.

A registered lock flag rises after a programmable run of consecutive comparisons whose low pulse stays within a width limit. It falls as soon as a low pulse outgrows that limit. The nominal comparison rate is about 10 kHz, far slower than the system clock.

Top module: `pfd_lock_detect`

## Requirements
- R1: While `rstN` is low at a clock edge, `upOut`, `downOut`, `errOut` and `lockedOut` are 0 and `lockN` is 1 after that edge, even if a flag was set before the reset.
- R2: A rising edge on `refIn` sets `upOut` on the third rising clock edge that samples `refIn` high. A rising edge on `fbIn` sets `downOut` on the third such edge.
- R3: When both `upOut` and `downOut` are 1, both return to 0 together after exactly RESET_DELAY (default 2) cycles. An input leading by d cycles keeps its flag high for d+2 cycles, and the follower's flag is high for 2 cycles.
- R4: `errOut` is 1 exactly while one and only one of `upOut` and `downOut` is 1, so its high width equals the phase lead d (0 when the edges coincide).
- R5: `lockN` is 1 while both flags are clear and 0 while either is set, so a comparison with lead d gives a low pulse of d+2 cycles.
- R6: If one input keeps producing rising edges while the other produces none, that input's flag stays set and `lockN` stays low until the other input's next edge clears it.
- R7: A comparison is good when its `lockN` low pulse lasts at most PULSE_LIMIT (default 4) cycles. `lockedOut` becomes 1 at the end of the LOCK_COUNT-th (default 16) consecutive good comparison since reset or since the last bad one, and not earlier.
- R8: Once a low pulse reaches PULSE_LIMIT+1 cycles, `lockedOut` goes to 0 on the next edge and the consecutive-good count restarts from zero. A pulse that was already over the limit when its flags clear does not count as good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the compared inputs |
| rstN | input | 1 | Active-low synchronous reset |
| refIn | input | 1 | Reference clock, asynchronous to clk |
| fbIn | input | 1 | Divided feedback clock, asynchronous to clk |
| upOut | output | 1 | Correction flag set by a reference edge |
| downOut | output | 1 | Correction flag set by a feedback edge |
| errOut | output | 1 | High while exactly one flag is set |
| lockN | output | 1 | Active-high lock indicator with low pulses while a flag is set |
| lockedOut | output | 1 | Registered lock flag after a run of good comparisons |

## Verification
An input edge reaches its flag, and therefore `errOut` and `lockN`, three rising clock edges after it is first sampled. The flags then clear RESET_DELAY edges after they overlap, and `lockedOut` follows one edge after the deciding cycle of the comparison. The bench drives inputs on falling edges and opens a fixed 40-cycle window for each comparison. It counts the high samples of each output taken on falling edges across that window, and reads the lock state at the window's end, when every result of that comparison has settled. The expected widths d+2, 2 and d, and the good/bad run model, are computed from the lead alone, so the counts do not depend on exact edge alignment.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Per-comparison verdicts passed from the datapath to the lock control.
  typedef struct packed {
    logic cmpGood;  // overlap cleared with the low pulse inside the limit
    logic cmpBad;   // low pulse just outgrew the limit
  } cmpStrobe_t;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic riseEdge
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], asyncIn};
      lastLevel <= syncChain[SYNC_STAGES-1];
    end
  end

  assign riseEdge = syncChain[SYNC_STAGES-1] & ~lastLevel;

endmodule

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_DELAY = 2,
  parameter int PULSE_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refIn,
  input  logic       fbIn,
  output logic       upFlag,
  output logic       downFlag,
  output cmpStrobe_t strobes
);

  localparam int DELAY_W = (RESET_DELAY < 2) ? 1 : $clog2(RESET_DELAY + 1);
  localparam int LOW_W   = $clog2(PULSE_LIMIT + 2);
  localparam logic [DELAY_W-1:0] DELAY_LAST = DELAY_W'(RESET_DELAY - 1);
  localparam logic [LOW_W-1:0]   LOW_LIMIT  = LOW_W'(PULSE_LIMIT);
  localparam logic [LOW_W-1:0]   LOW_SAT    = LOW_W'(PULSE_LIMIT + 1);

  logic               refEdge, fbEdge;
  logic               bothSet, anySet, clearNow;
  logic [DELAY_W-1:0] delayCnt;
  logic [LOW_W-1:0]   lowCnt;

  pfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) uRefSync (
    .clk(clk), .rstN(rstN), .asyncIn(refIn), .riseEdge(refEdge)
  );

  pfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) uFbSync (
    .clk(clk), .rstN(rstN), .asyncIn(fbIn), .riseEdge(fbEdge)
  );

  assign bothSet  = upFlag & downFlag;
  assign anySet   = upFlag | downFlag;
  assign clearNow = bothSet && (delayCnt == DELAY_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upFlag   <= 1'b0;
      downFlag <= 1'b0;
      delayCnt <= '0;
      lowCnt   <= '0;
    end else begin
      // A new edge wins over the clear so that no comparison is lost.
      upFlag   <= refEdge | (upFlag & ~clearNow);
      downFlag <= fbEdge  | (downFlag & ~clearNow);
      if (clearNow || !bothSet) delayCnt <= '0;
      else                      delayCnt <= delayCnt + DELAY_W'(1);
      if (clearNow || !anySet)  lowCnt <= '0;
      else if (lowCnt != LOW_SAT) lowCnt <= lowCnt + LOW_W'(1);
    end
  end

  // lowCnt holds the number of earlier set cycles in this pulse.
  assign strobes.cmpGood = clearNow && (lowCnt < LOW_LIMIT);
  assign strobes.cmpBad  = anySet && (lowCnt == LOW_LIMIT);

  p_up_from_ref_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(upFlag) |-> $past(refEdge));

  p_down_from_fb_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(downFlag) |-> $past(fbEdge));

  p_overlap_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bothSet && delayCnt == DELAY_LAST && !refEdge && !fbEdge) |=> (!upFlag && !downFlag));

  p_lone_up_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upFlag && !downFlag && !fbEdge) |=> upFlag);

endmodule

// File: rtl/pfd_lock_ctrl.sv
module pfd_lock_ctrl
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  cmpStrobe_t strobes,
  output logic       lockedFlag
);

  localparam int GOOD_W = (LOCK_COUNT < 2) ? 1 : $clog2(LOCK_COUNT);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  logic [GOOD_W-1:0] goodCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt    <= '0;
      lockedFlag <= 1'b0;
    end else if (strobes.cmpBad) begin
      goodCnt    <= '0;
      lockedFlag <= 1'b0;
    end else if (strobes.cmpGood) begin
      if (goodCnt != GOOD_LAST) goodCnt <= goodCnt + GOOD_W'(1);
      if (goodCnt == GOOD_LAST) lockedFlag <= 1'b1;
    end
  end

  p_lock_needs_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedFlag) |-> ($past(strobes.cmpGood) && $past(goodCnt) == GOOD_LAST));

  p_bad_drops_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cmpBad |=> (!lockedFlag && goodCnt == '0));

endmodule

// File: rtl/pfd_lock_detect.sv
module pfd_lock_detect
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_DELAY = 2,
  parameter int PULSE_LIMIT = 4,
  parameter int LOCK_COUNT  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic refIn,
  input  logic fbIn,
  output logic upOut,
  output logic downOut,
  output logic errOut,
  output logic lockN,
  output logic lockedOut
);

  cmpStrobe_t strobes;

  pfd_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .RESET_DELAY(RESET_DELAY),
    .PULSE_LIMIT(PULSE_LIMIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .upFlag(upOut), .downFlag(downOut), .strobes(strobes)
  );

  pfd_lock_ctrl #(.LOCK_COUNT(LOCK_COUNT)) uCtrl (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lockedFlag(lockedOut)
  );

  assign errOut = upOut ^ downOut;
  assign lockN  = ~(upOut | downOut);

endmodule

// File: tb/sim_pfd_lock_detect.sv
module sim_pfd_lock_detect;

  localparam int WIN      = 40;
  localparam int HIGH_LEN = 10;
  localparam int LIMIT    = 4;
  localparam int RUN_LEN  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic fbIn = 1'b0;
  logic upOut, downOut, errOut, lockN, lockedOut;

  int vectors = 0;
  int misses  = 0;
  int goodRun = 0;

  pfd_lock_detect u0 (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .upOut(upOut), .downOut(downOut), .errOut(errOut),
    .lockN(lockN), .lockedOut(lockedOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int absVal(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic bit pulseGood(input int lead);
    return (absVal(lead) + 2) <= LIMIT;
  endfunction

  task automatic runWindow(input bit refOn, input bit fbOn, input int tR, input int tF,
                           output int upC, output int downC, output int errC, output int lowC);
    upC = 0; downC = 0; errC = 0; lowC = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      upC   += int'(upOut);
      downC += int'(downOut);
      errC  += int'(errOut);
      lowC  += int'(!lockN);
      refIn = refOn && (k >= tR) && (k < tR + HIGH_LEN);
      fbIn  = fbOn  && (k >= tF) && (k < tF + HIGH_LEN);
    end
    @(negedge clk);
  endtask

  // lead > 0: reference first by lead cycles; lead < 0: feedback first.
  task automatic compareOnce(input int lead);
    int upC, downC, errC, lowC, tR, tF, d;
    d  = absVal(lead);
    tR = (lead < 0) ? d : 0;
    tF = (lead < 0) ? 0 : d;
    runWindow(1'b1, 1'b1, tR, tF, upC, downC, errC, lowC);
    chk("R3 up width",   upC,   (lead > 0) ? d + 2 : 2);
    chk("R3 down width", downC, (lead < 0) ? d + 2 : 2);
    chk("R4 err width",  errC,  d);
    chk("R5 lockN low width", lowC, d + 2);
    chk("R5 lockN idle", int'(lockN), 1);
    if (pulseGood(lead)) goodRun++;
    else                 goodRun = 0;
    chk("R7/R8 locked flag", int'(lockedOut), (goodRun >= RUN_LEN) ? 1 : 0);
  endtask

  initial begin
    int upC, downC, errC, lowC;
    int lead;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (5) @(negedge clk);
    chk("R1 up after reset", int'(upOut), 0);
    chk("R1 down after reset", int'(downOut), 0);
    chk("R1 err after reset", int'(errOut), 0);
    chk("R1 lockN after reset", int'(lockN), 1);
    chk("R1 locked after reset", int'(lockedOut), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R2: reference edge reaches upOut on the third sampling edge
    refIn = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 up not yet set", int'(upOut), 0);
    @(negedge clk);
    chk("R2 up set on third edge", int'(upOut), 1);
    fbIn = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 down not yet set", int'(downOut), 0);
    @(negedge clk);
    chk("R2 down set on third edge", int'(downOut), 1);
    chk("R3 both set together", int'(upOut & downOut), 1);
    @(negedge clk);
    chk("R3 overlap second cycle", int'(upOut & downOut), 1);
    @(negedge clk);
    chk("R3 cleared after two", int'(upOut | downOut), 0);
    refIn = 1'b0; fbIn = 1'b0;
    repeat (5) @(negedge clk);

    // R7: directed lock build-up, one short of the run then the full run
    goodRun = 0;
    for (int i = 0; i < RUN_LEN - 1; i++) compareOnce(i % 3 - 1);
    chk("R7 not locked after 15 good", int'(lockedOut), 0);
    compareOnce(2);
    chk("R7 locked after 16 good", int'(lockedOut), 1);
    compareOnce(-2);
    // R8: one over the limit drops the lock
    compareOnce(3);
    chk("R8 lock dropped", int'(lockedOut), 0);

    // R6: feedback missing for a whole window
    for (int i = 0; i < RUN_LEN; i++) compareOnce(0);
    chk("R7 relocked", int'(lockedOut), 1);
    runWindow(1'b1, 1'b0, 0, 0, upC, downC, errC, lowC);
    goodRun = 0;
    chk("R6 up held without feedback", int'(upOut), 1);
    chk("R6 lockN held low", int'(lockN), 0);
    chk("R8 lock lost on wide pulse", int'(lockedOut), 0);
    runWindow(1'b0, 1'b1, 0, 0, upC, downC, errC, lowC);
    chk("R6 feedback edge releases", int'(lockN), 1);
    chk("R8 late clear not good", int'(lockedOut), 0);

    // Random leads, both directions, around and beyond the limit
    for (int i = 0; i < 60; i++) begin
      lead = int'($urandom_range(0, 6));
      if ($urandom_range(0, 1) == 1) lead = -lead;
      if ($urandom_range(0, 3) != 0) lead = lead % 3;
      compareOnce(lead);
    end

    // R1: reset while a flag is set
    refIn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 up set before reset", int'(upOut), 1);
    rstN = 1'b0; refIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 up cleared by reset", int'(upOut), 0);
    chk("R1 lockN high in reset", int'(lockN), 1);
    chk("R1 locked cleared", int'(lockedOut), 0);
    rstN = 1'b1;
    goodRun = 0;
    repeat (5) @(negedge clk);
    compareOnce(1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 200000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule